// File: doc/BRIEF.md
# Full-Period LFSR Sequence Generator

This block is a pseudo-noise source of configurable width that walks through all 2^W register states before it repeats, one state per enabled clock. A plain maximal-length linear feedback shift register locks out one state and so has period 2^W-1. Here one pattern is detected and the feedback bit is flipped while that pattern is present, which splices the missing state into the cycle.

The register shifts toward the MSB and takes its new bit in at the LSB. The MSB is the serial output. The base feedback is the XNOR of the tapped bits, so the locked-out state of the base register is all ones, and the reset value of all zeros is an ordinary state on the cycle. The detector fires when every bit below the MSB is one. It can be built as a wide AND over those bits or as a small counter that tracks the run of ones shifted in. Both give the same sequence. A consumer that needs a W-bit word of fresh bits should sample once every W enabled steps.

Top module: `fullcycle_lfsr`

## Requirements
- R1: A high `rst` at a clock edge loads all zeros into `state_o`, whatever `step_en` is.
- R2: With `rst` low and `step_en` low, `state_o` keeps its value across the clock edge.
- R3: On each enabled edge the new `state_o[W-1:1]` equals the old `state_o[W-2:0]`, so the new bit enters at bit 0.
- R4: `bit_o` always equals `state_o[W-1]`.
- R5: The base feedback bit is the inverse of the XOR of the tapped bits. For W=8 the taps are bits 7, 5, 4 and 3, and for W=5 they are bits 4 and 2. From all zeros the first enabled step gives 0...01.
- R6: An enabled step from the state with MSB 0 and all lower bits 1 goes to all ones.
- R7: An enabled step from all ones goes to all ones except bit 0, which is 0.
- R8: After exactly 2^W enabled steps from any state, `state_o` is back at its start value, and within those steps every one of the 2^W values appears exactly once. Idle cycles in between do not change this.
- R9: The counter-based detector (`DETECT` = serial) produces a sequence identical to the wide-AND detector for the same width.
- R10: `WIDTH` may be any value from 3 to 16. Each width uses a fixed maximal-length tap set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| step_en | input | 1 | Advance the sequence by one state on this edge |
| bit_o | output | 1 | Serial pseudo-noise bit, the MSB of the state |
| state_o | output | WIDTH | Full register state |

## Verification
The hardest situation to reach is the splice around the all-ones state. It occurs once per 2^W steps, only at a pattern the feedback network itself reaches, and it cannot be loaded from the ports. The stimulus therefore runs a complete period of enabled steps from reset, with idle cycles interleaved. This passes through the detector pattern and the all-ones state naturally, and the scoreboard checks the exact next states there. The counter-based detector is run side by side with a wide-AND instance of the same width across a full period, so that its run-length tracking is compared at the one point where it matters.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

    localparam int MIN_WIDTH = 3;
    localparam int MAX_WIDTH = 16;

    typedef enum logic [0:0] {
        DET_WIDE   = 1'b0,
        DET_SERIAL = 1'b1
    } det_mode_e;

    // Maximal-length tap masks for an XNOR Fibonacci register shifting toward the MSB.
    function automatic logic [31:0] tap_mask(input int w);
        logic [31:0] m;
        case (w)
            3:       m = 32'h0000_0006;
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0829;
            13:      m = 32'h0000_100D;
            14:      m = 32'h0000_2015;
            15:      m = 32'h0000_6000;
            16:      m = 32'h0000_D008;
            default: m = 32'h0;
        endcase
        return m;
    endfunction

    function automatic int cnt_width(input int w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/fcl_detect.sv
module fcl_detect #(
    parameter int                W      = 8,
    parameter fcl_pkg::det_mode_e DETECT = fcl_pkg::DET_WIDE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic [W-2:0] low_bits,
    input  logic         bit_in,
    output logic         hit
);
    localparam int CW = fcl_pkg::cnt_width(W);

    generate
        if (DETECT == fcl_pkg::DET_WIDE) begin : g_wide
            logic unused_wide;
            assign unused_wide = ^{clk, rst, step_en, bit_in};
            assign hit = &low_bits;
        end else begin : g_serial
            logic [CW-1:0] run_q;
            logic          unused_serial;
            assign unused_serial = ^low_bits;
            assign hit = (run_q == CW'(W - 1));
            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q <= '0;
                end else if (step_en) begin
                    if (!bit_in)
                        run_q <= '0;
                    else if (!hit)
                        run_q <= run_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fcl_core.sv
module fcl_core #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   TAPS = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         hit,
    output logic [W-1:0] state,
    output logic         bit_in
);
    logic base_fb;

    always_comb begin
        base_fb = ~(^(state & TAPS));
        bit_in  = base_fb ^ hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (step_en)
            state <= {state[W-2:0], bit_in};
    end

endmodule

// File: rtl/fullcycle_lfsr.sv
module fullcycle_lfsr #(
    parameter int                 WIDTH  = 8,
    parameter fcl_pkg::det_mode_e DETECT = fcl_pkg::DET_WIDE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    output logic             bit_o,
    output logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] TAPS = WIDTH'(fcl_pkg::tap_mask(WIDTH));

    logic             hit;
    logic             bit_in;
    logic [WIDTH-1:0] state;

    fcl_detect #(.W(WIDTH), .DETECT(DETECT)) u_det (
        .clk      (clk),
        .rst      (rst),
        .step_en  (step_en),
        .low_bits (state[WIDTH-2:0]),
        .bit_in   (bit_in),
        .hit      (hit)
    );

    fcl_core #(.W(WIDTH), .TAPS(TAPS)) u_core (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .hit     (hit),
        .state   (state),
        .bit_in  (bit_in)
    );

    assign state_o = state;
    assign bit_o   = state[WIDTH-1];

endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         step_en,
    input logic         bit_o,
    input logic [W-1:0] state_o
);
    logic unused_chk;
    assign unused_chk = bit_o;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (state_o == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state_o));

    assert_shift_left_R3: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (state_o[W-1:1] == $past(state_o[W-2:0])));

    assert_enter_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (step_en && state_o == {1'b0, {(W-1){1'b1}}}) |=> (&state_o));

    assert_leave_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (step_en && (&state_o)) |=> (state_o == {{(W-1){1'b1}}, 1'b0}));

endmodule

bind fullcycle_lfsr fcl_checker #(.W(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .bit_o   (bit_o),
    .state_o (state_o)
);

// File: tb/sim_fullcycle_lfsr.sv
module sim_fullcycle_lfsr;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en0 = 1'b0;
    logic en1 = 1'b0;

    logic       b0, b1, b2;
    logic [7:0] s0;
    logic [4:0] s1, s2;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fullcycle_lfsr #(.WIDTH(8), .DETECT(fcl_pkg::DET_WIDE)) u0 (
        .clk(clk), .rst(rst), .step_en(en0), .bit_o(b0), .state_o(s0));
    fullcycle_lfsr #(.WIDTH(5), .DETECT(fcl_pkg::DET_SERIAL)) u1 (
        .clk(clk), .rst(rst), .step_en(en1), .bit_o(b1), .state_o(s1));
    fullcycle_lfsr #(.WIDTH(5), .DETECT(fcl_pkg::DET_WIDE)) u2 (
        .clk(clk), .rst(rst), .step_en(en1), .bit_o(b2), .state_o(s2));

    typedef struct {
        logic [7:0] prev;
        logic       en;
        logic       rs;
    } item_t;

    item_t sbq[$];
    bit    seen8 [256];
    bit    seen5 [32];
    bit    cov_on = 1'b0;
    int    dup8   = 0;
    int    hit6   = 0;
    int    hit7   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic drive(input logic e, input logic r);
        @(negedge clk);
        en0 = e;
        rst = r;
        sbq.push_back('{prev: s0, en: e, rs: r});
    endtask

    // monitor: pops the item driven before the last rising edge and compares
    initial begin
        forever begin
            int n;
            @(posedge clk);
            n = sbq.size();
            @(negedge clk);
            repeat (n) begin
                item_t it;
                it = sbq.pop_front();
                chk(b0 == s0[7], "R4 serial bit", int'(b0), int'(s0[7]));
                if (it.rs) begin
                    chk(s0 == 8'h00, "R1 reset", int'(s0), 0);
                end else if (!it.en) begin
                    chk(s0 == it.prev, "R2 hold", int'(s0), int'(it.prev));
                end else begin
                    chk(s0[7:1] == it.prev[6:0], "R3 shift", int'(s0[7:1]), int'(it.prev[6:0]));
                    if (it.prev == 8'h7F) begin
                        hit6++;
                        chk(s0 == 8'hFF, "R6 enter all-ones", int'(s0), 'hFF);
                    end
                    if (it.prev == 8'hFF) begin
                        hit7++;
                        chk(s0 == 8'hFE, "R7 leave all-ones", int'(s0), 'hFE);
                    end
                    if (it.prev == 8'h00)
                        chk(s0 == 8'h01, "R5 first step", int'(s0), 1);
                    if (cov_on) begin
                        if (seen8[s0]) dup8++;
                        seen8[s0] = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] start8;
        logic [4:0] start5;
        logic [4:0] prev5;
        int         cnt;
        int         steps;
        int         dup5;
        int         h6, h7;

        @(negedge clk);
        chk(s0 == 8'h00, "R1 reset state u0", int'(s0), 0);
        chk(b0 == 1'b0, "R4 reset serial", int'(b0), 0);
        chk(s1 == 5'h00, "R1 reset state u1", int'(s1), 0);

        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);   // R5: 00 -> 01
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk(s0 == 8'h01, "R5 state after one step", int'(s0), 1);
        chk(s0 == 8'h01, "R2 held after idle", int'(s0), 1);

        // R8: full period with idle gaps
        for (int i = 0; i < 256; i++) seen8[i] = 1'b0;
        start8 = s0;
        cov_on = 1'b1;
        steps  = 0;
        for (int i = 0; steps < 256; i++) begin
            if (i % 7 == 3) begin
                drive(1'b0, 1'b0);
            end else begin
                drive(1'b1, 1'b0);
                steps++;
            end
        end
        drive(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        cov_on = 1'b0;
        cnt = 0;
        for (int i = 0; i < 256; i++) if (seen8[i]) cnt++;
        chk(s0 == start8, "R8 return to start", int'(s0), int'(start8));
        chk(cnt == 256, "R8 distinct states", cnt, 256);
        chk(dup8 == 0, "R8 no repeats", dup8, 0);
        chk(hit6 > 0, "R6 transition reached", hit6, 1);
        chk(hit7 > 0, "R7 transition reached", hit7, 1);

        // R1: reset wins over enable mid-sequence
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        @(negedge clk);
        chk(s0 == 8'h00, "R1 reset while enabled", int'(s0), 0);

        // R9/R8 on the counter-based detector, W=5
        for (int i = 0; i < 32; i++) seen5[i] = 1'b0;
        start5 = s1;
        dup5 = 0;
        h6 = 0;
        h7 = 0;
        @(negedge clk);
        en1 = 1'b1;
        for (int i = 0; i < 32; i++) begin
            prev5 = s1;
            @(negedge clk);
            chk(s1 == s2, "R9 serial vs wide detector", int'(s1), int'(s2));
            chk(b1 == s1[4], "R4 serial bit W5", int'(b1), int'(s1[4]));
            if (prev5 == 5'h0F) begin
                h6++;
                chk(s1 == 5'h1F, "R6 W5 enter all-ones", int'(s1), 'h1F);
            end
            if (prev5 == 5'h1F) begin
                h7++;
                chk(s1 == 5'h1E, "R7 W5 leave all-ones", int'(s1), 'h1E);
            end
            if (seen5[s1]) dup5++;
            seen5[s1] = 1'b1;
        end
        en1 = 1'b0;
        cnt = 0;
        for (int i = 0; i < 32; i++) if (seen5[i]) cnt++;
        chk(s1 == start5, "R8 W5 return to start", int'(s1), int'(start5));
        chk(cnt == 32, "R8 W5 distinct states", cnt, 32);
        chk(dup5 == 0, "R8 W5 no repeats", dup5, 0);
        chk(h6 == 1 && h7 == 1, "R10 W5 tap set splices once", h6 + h7, 2);

        finish_run();
    end

endmodule